// File: doc/BRIEF.md
# Pairable 8-bit Register File

This block holds the working registers of a small 8-bit processor core: an accumulator and six general byte registers (B, C, D, E, H, L). Each byte register is read through either of two independent combinational read ports and written through one byte write port. The accumulator is the register the arithmetic and logic unit reads for one operand and writes its result into. For a one-operand logic operation it is both the source and the destination. The routing that does this lies outside this block.

The general registers also group into three 16-bit pairs: BC, DE and HL. The first-named register of each pair is the high byte. One pair port reads a whole pair and can load a full 16-bit value into a pair at one clock edge. The HL pair is always presented as the memory-operand address. A dedicated pair-add adds BC, DE or HL into HL and reports the carry out of bit 15. This pair-add is the only 16-bit arithmetic in the block.

Register codes: 0 = A, 1 = B, 2 = C, 3 = D, 4 = E, 5 = H, 6 = L, 7 = unused. Pair codes: 0 = BC, 1 = DE, 2 = HL, 3 = unused.

Top module: `pair_reg_file`

## Requirements
- R1: While `rstN` is low, all seven registers and `addCarry` are cleared to zero at each clock edge.
- R2: `rdDataA` and `rdDataB` combinationally show the register named by `rdSelA` / `rdSelB` (register codes above). Code 7 reads as zero.
- R3: With `wrEn` high, `wrData` is stored into the register named by `wrSel` at the clock edge, and no other register changes. With `wrSel` = 7 nothing changes.
- R4: `pairRdData` combinationally shows the pair named by `pairSel`, with the high byte in bits 15:8 (B, D or H) and the low byte in bits 7:0 (C, E or L). Code 3 reads as zero.
- R5: With `pairWrEn` high, `pairWrData[15:8]` and `pairWrData[7:0]` are stored into the high and low registers of the selected pair at the same clock edge. Pair code 3 writes nothing.
- R6: When a pair write and a byte write name the same register in one cycle, the pair write value is stored. A byte write to a register outside the pair still takes effect in that cycle.
- R7: `memAddr` always equals the current {H, L} value.
- R8: With `addEn` high and `addSel` naming a pair, HL becomes the low 16 bits of HL + pair, and `addCarry` becomes bit 16 of that sum. Both operands are the values from before the edge. No other register changes because of the add.
- R9: A pair-add takes priority over a pair write or a byte write aimed at H or L in the same cycle.
- R10: `addCarry` keeps its value in every cycle without a valid pair-add, including cycles where `addSel` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| rdSelA | input | 3 | Register code for read port A |
| rdDataA | output | 8 | Read port A data |
| rdSelB | input | 3 | Register code for read port B |
| rdDataB | output | 8 | Read port B data |
| wrEn | input | 1 | Byte write enable |
| wrSel | input | 3 | Register code for the byte write |
| wrData | input | 8 | Byte write data |
| pairSel | input | 2 | Pair code for the pair read and pair write |
| pairRdData | output | 16 | Selected pair, high byte on top |
| pairWrEn | input | 1 | Pair write enable |
| pairWrData | input | 16 | Pair write data |
| addEn | input | 1 | Pair-add enable |
| addSel | input | 2 | Pair code added into HL |
| addCarry | output | 1 | Carry out of bit 15 from the last pair-add |
| memAddr | output | 16 | Memory-operand address (HL) |

## Verification
The hardest case to reach from the ports is a single cycle in which a pair-add, a pair write and a byte write all collide on H or L. Random traffic with independent enables rarely makes that three-way overlap. Directed cycles therefore load operand values that force a carry and then fire all three strobes together. They also cover HL added to itself, where both operands are the pre-edge value. Long random runs are then compared, every cycle, against a behavioural byte-array model that applies the writes in priority order.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 7;
  localparam int NUM_PAIRS  = 3;
  localparam int REG_SEL_W  = $clog2(NUM_REGS + 1);
  localparam int PAIR_SEL_W = $clog2(NUM_PAIRS + 1);
  localparam int WIDE_W     = 2 * DATA_W;
  localparam int HL_PAIR    = NUM_PAIRS - 1;
  localparam int H_IDX      = 2 * HL_PAIR + 1;
  localparam int L_IDX      = 2 * HL_PAIR + 2;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_BYTE = 2'd1,
    SRC_PAIR = 2'd2,
    SRC_SUM  = 2'd3
  } regSrc_e;

  typedef struct packed {
    regSrc_e [NUM_REGS-1:0] src;
    logic                   carryWe;
  } prfStrobes_t;
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_SEL_W-1:0]  wrSel,
  input  logic                  pairWrEn,
  input  logic [PAIR_SEL_W-1:0] pairSel,
  input  logic                  addEn,
  input  logic [PAIR_SEL_W-1:0] addSel,
  output prfStrobes_t           strobes
);
  logic pairValid;
  logic addValid;

  assign pairValid = pairWrEn && (int'(pairSel) < NUM_PAIRS);
  assign addValid  = addEn && (int'(addSel) < NUM_PAIRS);

  // Priority rises down the block: byte write, pair write, pair-add.
  always_comb begin
    strobes.carryWe = addValid;
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes.src[i] = SRC_KEEP;
      if (wrEn && (int'(wrSel) == i)) strobes.src[i] = SRC_BYTE;
      if (pairValid && ((int'(pairSel) * 2 + 1 == i) || (int'(pairSel) * 2 + 2 == i)))
        strobes.src[i] = SRC_PAIR;
      if (addValid && ((i == H_IDX) || (i == L_IDX)))
        strobes.src[i] = SRC_SUM;
    end
  end

  // R9
  add_over_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    addValid |-> (strobes.src[H_IDX] == SRC_SUM) && (strobes.src[L_IDX] == SRC_SUM));

  // R6
  pair_over_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !addValid) |->
      (strobes.src[int'(pairSel) * 2 + 1] == SRC_PAIR) &&
      (strobes.src[int'(pairSel) * 2 + 2] == SRC_PAIR));

  // R3
  unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !pairValid && !addValid) |-> (strobes == '0));
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  prfStrobes_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [WIDE_W-1:0]     pairWrData,
  input  logic [REG_SEL_W-1:0]  rdSelA,
  input  logic [REG_SEL_W-1:0]  rdSelB,
  input  logic [PAIR_SEL_W-1:0] pairSel,
  input  logic [PAIR_SEL_W-1:0] addSel,
  output logic [DATA_W-1:0]     rdDataA,
  output logic [DATA_W-1:0]     rdDataB,
  output logic [WIDE_W-1:0]     pairRdData,
  output logic [WIDE_W-1:0]     memAddr,
  output logic                  addCarry
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [WIDE_W-1:0] hlVal;
  logic [WIDE_W-1:0] addOperand;
  logic [WIDE_W:0]   pairSum;

  function automatic logic [DATA_W-1:0] pickByte(input logic [REG_SEL_W-1:0] sel,
                                                 input logic [DATA_W-1:0] r [NUM_REGS]);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(sel) == i) v = r[i];
    return v;
  endfunction

  function automatic logic [WIDE_W-1:0] pickPair(input logic [PAIR_SEL_W-1:0] sel,
                                                 input logic [DATA_W-1:0] r [NUM_REGS]);
    logic [WIDE_W-1:0] v;
    v = '0;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (int'(sel) == p) v = {r[2*p+1], r[2*p+2]};
    return v;
  endfunction

  assign hlVal      = {regs[H_IDX], regs[L_IDX]};
  assign addOperand = pickPair(addSel, regs);
  assign pairSum    = {1'b0, hlVal} + {1'b0, addOperand};

  assign rdDataA    = pickByte(rdSelA, regs);
  assign rdDataB    = pickByte(rdSelB, regs);
  assign pairRdData = pickPair(pairSel, regs);
  assign memAddr    = hlVal;

  // Odd indices hold the high byte of a pair, even indices above zero the low byte.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam bit IS_HI = (g % 2) == 1;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[g] <= '0;
      end else begin
        case (strobes.src[g])
          SRC_BYTE: regs[g] <= wrData;
          SRC_PAIR: regs[g] <= IS_HI ? pairWrData[WIDE_W-1:DATA_W] : pairWrData[DATA_W-1:0];
          SRC_SUM:  regs[g] <= IS_HI ? pairSum[WIDE_W-1:DATA_W] : pairSum[DATA_W-1:0];
          default:  regs[g] <= regs[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                addCarry <= 1'b0;
    else if (strobes.carryWe) addCarry <= pairSum[WIDE_W];
  end

  // R8
  pair_add_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.carryWe |=> ({addCarry, memAddr} == $past({1'b0, hlVal}) + $past({1'b0, addOperand})));

  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.carryWe |=> $stable(addCarry));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (memAddr == '0) && !addCarry && (regs[0] == '0));
endmodule

// File: rtl/pair_reg_file.sv
module pair_reg_file
  import prf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_SEL_W-1:0]  rdSelA,
  output logic [DATA_W-1:0]     rdDataA,
  input  logic [REG_SEL_W-1:0]  rdSelB,
  output logic [DATA_W-1:0]     rdDataB,
  input  logic                  wrEn,
  input  logic [REG_SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [PAIR_SEL_W-1:0] pairSel,
  output logic [WIDE_W-1:0]     pairRdData,
  input  logic                  pairWrEn,
  input  logic [WIDE_W-1:0]     pairWrData,
  input  logic                  addEn,
  input  logic [PAIR_SEL_W-1:0] addSel,
  output logic                  addCarry,
  output logic [WIDE_W-1:0]     memAddr
);
  prfStrobes_t strobes;

  prf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .pairWrEn(pairWrEn), .pairSel(pairSel), .addEn(addEn), .addSel(addSel),
    .strobes(strobes)
  );

  prf_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .pairWrData(pairWrData), .rdSelA(rdSelA), .rdSelB(rdSelB),
    .pairSel(pairSel), .addSel(addSel), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .pairRdData(pairRdData), .memAddr(memAddr), .addCarry(addCarry)
  );

  // R5
  hl_pair_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairWrEn && (pairSel == 2'd2) && !(addEn && (addSel != 2'd3))) |=>
      (memAddr == $past(pairWrData)));
endmodule

// File: tb/pair_reg_file_tb.sv
module pair_reg_file_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [7:0]  rdDataA, rdDataB, wrData = '0;
  logic [1:0]  pairSel = '0, addSel = '0;
  logic [15:0] pairRdData, memAddr, pairWrData = '0;
  logic        wrEn = 1'b0, pairWrEn = 1'b0, addEn = 1'b0, addCarry;

  int checks = 0;
  int errors = 0;
  int model [7];
  int modelCarry;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pair_reg_file dut_i (
    .clk(clk), .rstN(rstN), .rdSelA(rdSelA), .rdDataA(rdDataA),
    .rdSelB(rdSelB), .rdDataB(rdDataB), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .pairSel(pairSel), .pairRdData(pairRdData),
    .pairWrEn(pairWrEn), .pairWrData(pairWrData), .addEn(addEn),
    .addSel(addSel), .addCarry(addCarry), .memAddr(memAddr)
  );

  function automatic int byteOf(int code);
    return (code < 7) ? model[code] : 0;
  endfunction

  function automatic int pairOf(int code);
    return (code < 3) ? (model[2*code+1] * 256 + model[2*code+2]) : 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check({tag, "/R2"}, "rdDataA", int'(rdDataA), byteOf(int'(rdSelA)));
    check({tag, "/R2"}, "rdDataB", int'(rdDataB), byteOf(int'(rdSelB)));
    check({tag, "/R4"}, "pairRdData", int'(pairRdData), pairOf(int'(pairSel)));
    check({tag, "/R7"}, "memAddr", int'(memAddr), pairOf(2));
    check({tag, "/R10"}, "addCarry", int'(addCarry), modelCarry);
  endtask

  // Drive inputs mid-cycle, compare, update the model, cross the edge.
  task automatic step(string tag);
    int nxt [7];
    int s;
    #1;
    compareAll(tag);
    for (int i = 0; i < 7; i++) nxt[i] = model[i];
    if (!rstN) begin
      for (int i = 0; i < 7; i++) nxt[i] = 0;
      modelCarry = 0;
    end else begin
      if (wrEn && wrSel < 7) nxt[wrSel] = int'(wrData);
      if (pairWrEn && pairSel < 3) begin
        nxt[2*pairSel+1] = int'(pairWrData[15:8]);
        nxt[2*pairSel+2] = int'(pairWrData[7:0]);
      end
      if (addEn && addSel < 3) begin
        s = pairOf(2) + pairOf(int'(addSel));
        nxt[5] = (s / 256) % 256;
        nxt[6] = s % 256;
        modelCarry = (s >= 65536) ? 1 : 0;
      end
    end
    @(posedge clk);
    for (int i = 0; i < 7; i++) model[i] = nxt[i];
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; pairWrEn = 0; addEn = 0;
  endtask

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 0;
    modelCarry = 0;
    @(negedge clk);
    // R1: reset, with busy strobes that must not matter.
    wrEn = 1; wrSel = 3'd1; wrData = 8'hAA; pairWrEn = 1; pairWrData = 16'hFFFF;
    step("R1");
    step("R1");
    idle();
    rstN = 1;
    for (int i = 0; i < 8; i++) begin
      rdSelA = 3'(i); rdSelB = 3'(7 - i); pairSel = 2'(i % 4);
      step("R1");
    end
    // R3: byte writes to every code, including the unused code 7.
    for (int i = 0; i < 8; i++) begin
      wrEn = 1; wrSel = 3'(i); wrData = 8'(8'h11 * (i + 1)); rdSelA = 3'(i);
      step("R3");
    end
    idle();
    step("R3");
    // R5: pair loads, including unused code 3.
    for (int p = 0; p < 4; p++) begin
      pairWrEn = 1; pairSel = 2'(p); pairWrData = 16'(16'h1234 + p * 16'h1111);
      step("R5");
    end
    idle();
    for (int p = 0; p < 4; p++) begin pairSel = 2'(p); step("R5"); end
    // R6: pair write and byte write on same register; byte to other register lands.
    pairWrEn = 1; pairSel = 2'd1; pairWrData = 16'hBEEF; wrEn = 1; wrSel = 3'd4; wrData = 8'h55;
    step("R6");
    wrSel = 3'd0; wrData = 8'h77; pairWrData = 16'hCAFE;
    step("R6");
    idle(); rdSelA = 3'd0; rdSelB = 3'd4; step("R6");
    // R8: carry-producing adds, HL+HL, and unused add code.
    pairWrEn = 1; pairSel = 2'd2; pairWrData = 16'hF000; step("R8");
    pairSel = 2'd0; pairWrData = 16'h1001; step("R8");
    idle(); addEn = 1; addSel = 2'd0; step("R8");
    addSel = 2'd2; step("R8");
    addSel = 2'd3; step("R10");
    idle(); step("R10");
    // R9: add collides with pair write and byte write on H and L.
    pairWrEn = 1; pairSel = 2'd2; pairWrData = 16'hFFFF; step("R9");
    pairWrData = 16'h0102; wrEn = 1; wrSel = 3'd6; wrData = 8'h99;
    addEn = 1; addSel = 2'd2; step("R9");
    idle(); step("R9");
    // Random traffic.
    for (int n = 0; n < 3000; n++) begin
      rdSelA = 3'($urandom); rdSelB = 3'($urandom); pairSel = 2'($urandom);
      addSel = 2'($urandom); wrSel = 3'($urandom); wrData = 8'($urandom);
      pairWrData = 16'($urandom);
      wrEn = 1'($urandom); pairWrEn = 1'($urandom); addEn = (($urandom % 3) == 0);
      step("RND");
    end
    idle();
    step("RND");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule